// File: doc/BRIEF.md
# Tape Machine for Binary Equality and Ordering

This block holds a short symbol tape and runs a single read/write head over it to decide how two binary numbers written on that tape relate. Software or a neighbouring block writes the tape one cell at a time through a load port. The left number goes first, most significant digit at cell 0. A separator follows it, then the right number, and then at least one blank cell. A start pulse launches a run.

The machine pairs one digit from each side per pass. It crosses each paired digit out with a marker symbol, walking back and forth over the separator. When the left side runs out, a final sweep checks whether anything is left over on the right.

In equality mode any mismatch ends the run with a reject. In greater-than mode a digit mismatch does not stop the run. The first mismatch is remembered in a small order register and the run goes on, so that the lengths settle the answer first. Equal lengths fall back on the remembered first difference.

Operands must be non-empty and free of leading zeros; the block does not clean its input. Every clock performs exactly one transition until the verdict is reached.

Top module: `tape_eq_machine`

## Requirements
- R1: Symbol codes are 0 blank, 1 digit zero, 2 digit one, 3 separator and 4 marker. The load port writes `load_sym` into cell `load_addr` on a clock edge. Cells beyond the last one read as blank.
- R2: A start pulse puts the head on cell 0 and latches `gt_mode`. On the edge after that pulse, `done` is low.
- R3: The machine makes one transition per clock. When both operands have n digits, and the run is not cut short by an equality-mode mismatch, `done` rises exactly 2(n+1)^2 clock edges after the start edge.
- R4: In equality mode, two identical operands give `accept` high.
- R5: In equality mode, operands of equal length that differ in any digit are rejected.
- R6: In equality mode, a right operand shorter than the left one is rejected.
- R7: In either mode, a right operand longer than the left one is rejected.
- R8: In greater-than mode, a left operand with more digits than the right one is accepted.
- R9: In greater-than mode with equal lengths, the most significant differing digit decides. A 1 on the left against a 0 on the right accepts; the opposite rejects.
- R10: In greater-than mode, identical operands are rejected.
- R11: Once `done` is high, it stays high and `accept` keeps its value until the next start pulse. `accept` is never high while `done` is low.
- R12: Load-port writes made while a run is in progress are ignored.
- R13: After reset, `done` and `accept` are low and the tape is blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one tape cell |
| load_addr | input | 5 | Cell index for a load |
| load_sym | input | 3 | Symbol code to write |
| gt_mode | input | 1 | 0 tests equality, 1 tests left greater than right |
| start | input | 1 | Begin a run from cell 0 |
| done | output | 1 | Verdict reached |
| accept | output | 1 | Verdict is true (valid with done) |

## Verification
Operand pairs are chosen so that each pair reaches a different exit of the transition graph:
- identical strings of one, three and fifteen digits, which finish through the left-exhausted sweep;
- an early digit mismatch;
- a right side that runs out during the search;
- a right side with digits left after the left side is used up.

Greater-than mode then repeats the length cases and adds equal-length pairs whose first difference points each way, plus identical strings. This separates a verdict taken from length from one taken from the remembered difference.

For equal-length runs the closed-form latency is compared on every clock, so a skipped or extra head step shows up. A load injected mid-run onto a digit that is still to be compared shows whether loads are really blocked while busy.

// File: rtl/tm_pkg.sv
package tm_pkg;

    typedef enum logic [2:0] {
        SYM_BLANK = 3'd0,
        SYM_ZERO  = 3'd1,
        SYM_ONE   = 3'd2,
        SYM_SEP   = 3'd3,
        SYM_MARK  = 3'd4
    } sym_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN,        // pick next left digit
        ST_HOLD0,       // carrying a 0 toward the separator
        ST_HOLD1,       // carrying a 1 toward the separator
        ST_FIND0,       // looking for a right digit to pair with 0
        ST_FIND1,       // looking for a right digit to pair with 1
        ST_RET_MARKS,   // walking left across crossed right digits
        ST_RET_DIGITS,  // walking left across live left digits
        ST_LEFT_EMPTY,  // left side used up, sweeping right side
        ST_ACCEPT,
        ST_REJECT
    } state_e;

    typedef enum logic [1:0] {
        ORD_NONE,
        ORD_LEFT,       // first difference favours the left operand
        ORD_RIGHT
    } order_e;

    typedef enum logic [1:0] {
        MV_STAY,
        MV_RIGHT,
        MV_LEFT
    } move_e;

    typedef struct packed {
        state_e next;
        logic   wr_mark;
        move_e  mv;
        logic   set_order;
        order_e order;
    } step_t;

    function automatic logic is_digit(sym_e s);
        return (s == SYM_ZERO) || (s == SYM_ONE);
    endfunction

    function automatic logic is_final(state_e s);
        return (s == ST_ACCEPT) || (s == ST_REJECT);
    endfunction

endpackage

// File: rtl/tm_tape.sv
module tm_tape
    import tm_pkg::*;
#(
    parameter int unsigned CELLS  = 32,
    parameter int unsigned ADDR_W = $clog2(CELLS),
    parameter int unsigned HEAD_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  sym_e              ld_sym,
    input  logic              mk_en,
    input  logic [HEAD_W-1:0] mk_addr,
    input  logic [HEAD_W-1:0] rd_addr,
    output sym_e              rd_sym
);

    sym_e cells [CELLS];

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        sym_e cell_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= SYM_BLANK;
            end else if (ld_en && ld_addr == ADDR_W'(c)) begin
                cell_q <= ld_sym;
            end else if (mk_en && mk_addr == HEAD_W'(c)) begin
                cell_q <= SYM_MARK;
            end
        end
        assign cells[c] = cell_q;
    end

    // Positions past the end of the tape read as blank
    always_comb begin
        if (rd_addr < HEAD_W'(CELLS)) rd_sym = cells[rd_addr[ADDR_W-1:0]];
        else                          rd_sym = SYM_BLANK;
    end

endmodule

// File: rtl/tm_rule.sv
module tm_rule
    import tm_pkg::*;
(
    input  state_e state,
    input  sym_e   sym,
    input  logic   gt,
    input  order_e order,
    output step_t  step
);

    always_comb begin
        step = '{next: state, wr_mark: 1'b0, mv: MV_STAY,
                 set_order: 1'b0, order: ORD_NONE};
        unique case (state)
            ST_SCAN: begin
                if (is_digit(sym)) begin
                    step.wr_mark = 1'b1;
                    step.mv      = MV_RIGHT;
                    step.next    = (sym == SYM_ONE) ? ST_HOLD1 : ST_HOLD0;
                end else if (sym == SYM_SEP) begin
                    step.mv   = MV_RIGHT;
                    step.next = ST_LEFT_EMPTY;
                end else begin
                    step.next = ST_REJECT;
                end
            end
            ST_HOLD0, ST_HOLD1: begin
                if (is_digit(sym)) begin
                    step.mv = MV_RIGHT;
                end else if (sym == SYM_SEP) begin
                    step.mv   = MV_RIGHT;
                    step.next = (state == ST_HOLD1) ? ST_FIND1 : ST_FIND0;
                end else begin
                    step.next = ST_REJECT;
                end
            end
            ST_FIND0, ST_FIND1: begin
                if (sym == SYM_MARK) begin
                    step.mv = MV_RIGHT;
                end else if (is_digit(sym)) begin
                    if ((sym == SYM_ONE) == (state == ST_FIND1)) begin
                        step.wr_mark = 1'b1;
                        step.mv      = MV_LEFT;
                        step.next    = ST_RET_MARKS;
                    end else if (gt) begin
                        step.wr_mark   = 1'b1;
                        step.mv        = MV_LEFT;
                        step.next      = ST_RET_MARKS;
                        step.set_order = 1'b1;
                        step.order     = (state == ST_FIND1) ? ORD_LEFT : ORD_RIGHT;
                    end else begin
                        step.next = ST_REJECT;
                    end
                end else if (sym == SYM_BLANK) begin
                    // right side exhausted while left still has digits
                    step.next = gt ? ST_ACCEPT : ST_REJECT;
                end else begin
                    step.next = ST_REJECT;
                end
            end
            ST_RET_MARKS: begin
                if (sym == SYM_MARK) begin
                    step.mv = MV_LEFT;
                end else if (sym == SYM_SEP) begin
                    step.mv   = MV_LEFT;
                    step.next = ST_RET_DIGITS;
                end else begin
                    step.next = ST_REJECT;
                end
            end
            ST_RET_DIGITS: begin
                if (is_digit(sym)) begin
                    step.mv = MV_LEFT;
                end else if (sym == SYM_MARK) begin
                    step.mv   = MV_RIGHT;
                    step.next = ST_SCAN;
                end else begin
                    step.next = ST_REJECT;
                end
            end
            ST_LEFT_EMPTY: begin
                if (sym == SYM_MARK) begin
                    step.mv = MV_RIGHT;
                end else if (sym == SYM_BLANK) begin
                    step.next = (!gt || order == ORD_LEFT) ? ST_ACCEPT : ST_REJECT;
                end else begin
                    step.next = ST_REJECT;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tape_eq_machine.sv
module tape_eq_machine
    import tm_pkg::*;
#(
    parameter  int unsigned CELLS  = 32,
    localparam int unsigned ADDR_W = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [2:0]        load_sym,
    input  logic              gt_mode,
    input  logic              start,
    output logic              done,
    output logic              accept
);

    localparam int unsigned HEAD_W = ADDR_W + 1;

    state_e            state_q;
    logic [HEAD_W-1:0] head_q;
    logic              gt_q;
    order_e            order_q;
    sym_e              cur_sym;
    step_t             step;
    logic              busy;
    logic              mk_en;
    logic              tape_ld;

    assign busy    = (state_q != ST_IDLE) && !is_final(state_q);
    assign mk_en   = busy && !start && step.wr_mark;
    assign tape_ld = load_en && !busy;

    tm_tape #(.CELLS(CELLS), .ADDR_W(ADDR_W), .HEAD_W(HEAD_W)) u_tape (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (tape_ld),
        .ld_addr (load_addr),
        .ld_sym  (sym_e'(load_sym)),
        .mk_en   (mk_en),
        .mk_addr (head_q),
        .rd_addr (head_q),
        .rd_sym  (cur_sym)
    );

    tm_rule u_rule (
        .state (state_q),
        .sym   (cur_sym),
        .gt    (gt_q),
        .order (order_q),
        .step  (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            head_q  <= '0;
            gt_q    <= 1'b0;
            order_q <= ORD_NONE;
        end else if (start) begin
            state_q <= ST_SCAN;
            head_q  <= '0;
            gt_q    <= gt_mode;
            order_q <= ORD_NONE;
        end else if (busy) begin
            state_q <= step.next;
            unique case (step.mv)
                MV_RIGHT: head_q <= head_q + HEAD_W'(1);
                MV_LEFT:  head_q <= head_q - HEAD_W'(1);
                default:  head_q <= head_q;
            endcase
            if (step.set_order && order_q == ORD_NONE) order_q <= step.order;
        end
    end

    assign done   = is_final(state_q);
    assign accept = (state_q == ST_ACCEPT);

endmodule

// File: rtl/tm_checker.sv
module tm_checker #(
    parameter int unsigned HEAD_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              accept,
    input logic              busy,
    input logic [HEAD_W-1:0] head
);

    a_r13_reset_idle: assert property (@(posedge clk)
        rst |=> (!done && !accept));

    a_r11_accept_needs_done: assert property (@(posedge clk) disable iff (rst)
        accept |-> done);

    a_r11_verdict_held: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(accept)));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && head == '0));

    a_r3_head_single_step: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (done || head == $past(head) + HEAD_W'(1)
                                    || head == $past(head) - HEAD_W'(1)));

endmodule

bind tape_eq_machine tm_checker #(.HEAD_W(HEAD_W)) u_tm_checker (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .accept (accept),
    .busy   (busy),
    .head   (head_q)
);

// File: tb/test_tape_eq_machine.sv
module test_tape_eq_machine;

    localparam int CLK_PERIOD = 10;
    localparam int CELLS      = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [4:0] load_addr = '0;
    logic [2:0] load_sym = '0;
    logic       gt_mode = 1'b0;
    logic       start = 1'b0;
    logic       done;
    logic       accept;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_eq_machine #(.CELLS(CELLS)) i_tape_eq_machine (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_sym  (load_sym),
        .gt_mode   (gt_mode),
        .start     (start),
        .done      (done),
        .accept    (accept)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: codes 0 blank, 1 zero, 2 one, 3 separator
    task automatic load_tape(input int lv, input int ll, input int rv, input int rl);
        for (int i = 0; i < CELLS; i++) begin
            int s;
            if (i < ll)                 s = lv[ll-1-i] ? 2 : 1;
            else if (i == ll)           s = 3;
            else if (i <= ll + rl)      s = rv[rl-1-(i-ll-1)] ? 2 : 1;
            else                        s = 0;
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = i[4:0];
            load_sym  = s[2:0];
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_case(input int lv, input int ll, input int rv, input int rl,
                            input bit gt, input string req,
                            input int inj_cycle, input int inj_addr, input int inj_sym);
        bit exp_acc;
        bit lat_known;
        int lat;
        int j;
        load_tape(lv, ll, rv, rl);
        if (gt) exp_acc = (ll > rl) || (ll == rl && lv > rv);
        else    exp_acc = (ll == rl) && (lv == rv);
        lat_known = (ll == rl) && (gt || lv == rv);
        lat = 2 * (ll + 1) * (ll + 1);
        @(negedge clk);
        gt_mode = gt;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R2 done low after start", done, 0);
        j = 0;
        while (j < 4000) begin
            @(negedge clk);
            if (load_en) load_en = 1'b0;
            j++;
            if (lat_known)
                check(done == (j >= lat), {req, " R3 latency"}, done, (j >= lat));
            if (!done) check(accept == 1'b0, "R11 accept without done", accept, 0);
            if (j == inj_cycle) begin
                load_en   = 1'b1;
                load_addr = inj_addr[4:0];
                load_sym  = inj_sym[2:0];
            end
            if (done) break;
        end
        load_en = 1'b0;
        check(done == 1'b1, {req, " done reached"}, done, 1);
        check(accept == exp_acc, {req, " verdict"}, accept, exp_acc);
        repeat (3) @(negedge clk);
        check(done == 1'b1 && accept == exp_acc, "R11 verdict held", accept, exp_acc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R13 done after reset", done, 0);
        check(accept == 1'b0, "R13 accept after reset", accept, 0);
        // R13 blank tape: start on a blank tape rejects
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check(done == 1'b1 && accept == 1'b0, "R13 blank tape rejects", accept, 0);

        run_case(5, 3, 5, 3, 1'b0, "R4 equal 101",      0, 0, 0);
        run_case(1, 1, 1, 1, 1'b0, "R4 equal 1",        0, 0, 0);
        run_case(15'h4D2B, 15, 15'h4D2B, 15, 1'b0, "R4 R1 equal 15 digits", 0, 0, 0);
        run_case(6, 3, 4, 3, 1'b0, "R5 digit mismatch", 0, 0, 0);
        run_case(5, 3, 2, 2, 1'b0, "R6 right shorter",  0, 0, 0);
        run_case(2, 2, 5, 3, 1'b0, "R7 right longer eq", 0, 0, 0);
        run_case(11, 4, 5, 3, 1'b1, "R8 left longer",   0, 0, 0);
        run_case(2, 2, 6, 3, 1'b1, "R7 right longer gt", 0, 0, 0);
        run_case(12, 4, 11, 4, 1'b1, "R9 left wins",    0, 0, 0);
        run_case(11, 4, 12, 4, 1'b1, "R9 right wins",   0, 0, 0);
        run_case(5, 3, 5, 3, 1'b1, "R10 equal gt",      0, 0, 0);
        // R12: cell 6 holds the last right digit (1); writing 0 there mid-run must not matter
        run_case(5, 3, 5, 3, 1'b0, "R12 load while busy", 5, 6, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule